// File: doc/BRIEF.md
# Adaptive Stream Prefetch Engine

This block watches the stream of first-level cache miss addresses and finds ascending runs of contiguous 128-byte lines. A prefetch line is twice the size of a first-level cache line. When a miss hits no known run, the block opens a new stream entry. It then requests the lines that follow the miss, one request per cycle, up to that stream's prefetch depth. Later misses that land inside a stream's prefetched window advance the stream and keep it topped up to its depth.

Depth is not fixed. A miss on a line that was requested but has not yet come back shows that the stream is running ahead of its prefetches, so that stream gains one line of depth. All streams draw from one shared line budget. When the budget is used up, the extra line is taken from the least recently hit stream. The outputs include a per-stream view of validity and depth, plus the total depth in use, so that the surrounding logic and the bench can observe how depth has been shared out.

Top module: `stream_prefetch_engine`

## Requirements
- R1: After reset no stream is valid, `st_total` is 0 and `pf_valid` is low.
- R2: A miss at line L (line = `miss_addr >> 7`) that lies in no stream's window opens a stream. It uses the lowest-index free entry, or the least recently hit entry when every entry is valid. The new stream's depth is the smaller of the start depth and the budget left by all other streams. The start depth is `cfg_init_depth` clamped to MAX_DEPTH. The stream then requests lines L+1 up to L+depth, in ascending order, at most one request per cycle.
- R3: No valid stream ever holds a depth above MAX_DEPTH.
- R4: The depths of all valid streams never sum to more than CAPACITY.
- R5: A miss at line L that lies in a stream's window is a hit. The window runs from the line after the last hit up to the last line requested. A hit moves the window start to L+1, and the stream then requests further lines up to L+depth.
- R6: A hit on a line that has been requested but not yet returned raises that stream's depth by one, provided the depth is below MAX_DEPTH. If the total depth is below CAPACITY, the extra line comes from the free budget. Otherwise one line is taken from the least recently hit other stream whose depth is above 1. If no such stream exists, the depth does not change.
- R7: `fill_valid` with `fill_line` equal to a stream's oldest outstanding line marks that line as returned. Fills of a stream must arrive in ascending order. A hit on a returned line leaves the depth unchanged.
- R8: While `miss_valid` is low, `miss_addr` has no effect: no stream is opened or changed by it.
- R9: Every hit or allocation makes that entry the most recently hit. Recency order among the entries stays a strict ranking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_init_depth | input | DEPTH_W | Start depth of new streams |
| miss_valid | input | 1 | A miss address is present |
| miss_addr | input | ADDR_W | Byte address of the miss |
| fill_valid | input | 1 | A prefetched line has returned |
| fill_line | input | LINE_W | Line address of the returned line |
| pf_valid | output | 1 | A prefetch request is issued this cycle |
| pf_line | output | LINE_W | Line address of the prefetch request |
| st_valid | output | NUM_STREAMS | Per-entry stream valid |
| st_depth | output | NUM_STREAMS*DEPTH_W | Per-entry depth, entry i at bits [i*DEPTH_W +: DEPTH_W] |
| st_total | output | TOT_W | Sum of depths of valid streams |

## Verification
The bench builds the engine with 4 streams, a maximum depth of 4 and a budget of 8 lines, while the defaults are 16, 8 and 32. With these small values, four streams at the start depth of 2 fill the budget exactly. A short series of in-flight hits therefore drives one stream into its depth ceiling, forces depth to be taken from the least recently hit stream, and skips a donor that is already at depth 1. A fifth stream then has to replace the oldest entry and receives only the single line of budget left over. With the start depth set above the maximum, the bench also shows that the start depth is clamped.

// File: rtl/spf_pkg.sv
package spf_pkg;
    typedef enum logic [1:0] {
        MISS_IDLE   = 2'd0,
        MISS_READY  = 2'd1,
        MISS_FLIGHT = 2'd2,
        MISS_NEW    = 2'd3
    } miss_kind_e;
endpackage

// File: rtl/spf_first_set.sv
module spf_first_set #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/spf_recency.sv
module spf_recency #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_v,
    input  logic [IDX_W-1:0]   touch_idx,
    output logic [N*IDX_W-1:0] ages
);
    logic [N-1:0][IDX_W-1:0] age_d, age_q;
    logic [N-1:0]            oldest;

    always_comb begin
        age_d = age_q;
        if (touch_v) begin
            for (int i = 0; i < N; i++) begin
                if (age_q[i] < age_q[touch_idx]) age_d[i] = age_q[i] + 1'b1;
            end
            age_d[touch_idx] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
        end else begin
            age_q <= age_d;
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) oldest[i] = (age_q[i] == IDX_W'(N - 1));
    end

    assign ages = age_q;

    assert_rank_strict_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1);
endmodule

// File: rtl/stream_prefetch_engine.sv
module stream_prefetch_engine
    import spf_pkg::*;
#(
    parameter int NUM_STREAMS = 16,
    parameter int MAX_DEPTH   = 8,
    parameter int CAPACITY    = 32,
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 128,
    parameter int DEPTH_W     = $clog2(MAX_DEPTH + 1),
    parameter int LINE_W      = ADDR_W - $clog2(LINE_BYTES),
    parameter int TOT_W       = $clog2(CAPACITY + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [DEPTH_W-1:0]             cfg_init_depth,
    input  logic                           miss_valid,
    input  logic [ADDR_W-1:0]              miss_addr,
    input  logic                           fill_valid,
    input  logic [LINE_W-1:0]              fill_line,
    output logic                           pf_valid,
    output logic [LINE_W-1:0]              pf_line,
    output logic [NUM_STREAMS-1:0]         st_valid,
    output logic [NUM_STREAMS*DEPTH_W-1:0] st_depth,
    output logic [TOT_W-1:0]               st_total
);
    localparam int IDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;
    localparam int OFS_W = $clog2(LINE_BYTES);

    typedef struct packed {
        logic               valid;
        logic [LINE_W-1:0]  head;   // first line after the last hit
        logic [LINE_W-1:0]  nreq;   // next line to request
        logic [LINE_W-1:0]  ret;    // oldest line not yet returned
        logic [DEPTH_W-1:0] depth;
    } entry_t;

    typedef struct packed {
        entry_t [NUM_STREAMS-1:0] tab;
        logic                     pf_v;
        logic [LINE_W-1:0]        pf_line;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_STREAMS-1:0]         pend_vec, hit_vec, free_vec;
    logic                           pend_f, hit_f, free_f;
    logic [IDX_W-1:0]               pend_i, hit_i, free_i;
    logic [NUM_STREAMS*IDX_W-1:0]   ages_flat;
    logic [IDX_W-1:0]               age [NUM_STREAMS];
    logic [LINE_W-1:0]              mline;
    logic [TOT_W-1:0]               tot;
    logic [DEPTH_W-1:0]             init_c;
    logic                           touch_v;
    logic [IDX_W-1:0]               touch_i;
    miss_kind_e                     kind;

    assign mline  = miss_addr[ADDR_W-1:OFS_W];
    assign init_c = (cfg_init_depth > DEPTH_W'(MAX_DEPTH)) ? DEPTH_W'(MAX_DEPTH) : cfg_init_depth;

    always_comb begin
        tot = '0;
        for (int i = 0; i < NUM_STREAMS; i++) begin
            age[i] = ages_flat[i*IDX_W +: IDX_W];
            if (s_q.tab[i].valid) tot = tot + TOT_W'(s_q.tab[i].depth);
            pend_vec[i] = s_q.tab[i].valid &&
                ({1'b0, s_q.tab[i].nreq} < ({1'b0, s_q.tab[i].head} + (LINE_W+1)'(s_q.tab[i].depth)));
            hit_vec[i]  = s_q.tab[i].valid && (s_q.tab[i].head <= mline) && (mline < s_q.tab[i].nreq);
            free_vec[i] = !s_q.tab[i].valid;
        end
    end

    spf_first_set #(.N(NUM_STREAMS), .IDX_W(IDX_W)) u_pick_issue (.vec(pend_vec), .found(pend_f), .idx(pend_i));
    spf_first_set #(.N(NUM_STREAMS), .IDX_W(IDX_W)) u_pick_hit   (.vec(hit_vec),  .found(hit_f),  .idx(hit_i));
    spf_first_set #(.N(NUM_STREAMS), .IDX_W(IDX_W)) u_pick_free  (.vec(free_vec), .found(free_f), .idx(free_i));

    spf_recency #(.N(NUM_STREAMS), .IDX_W(IDX_W)) u_recency (
        .clk(clk), .rst_n(rst_n), .touch_v(touch_v), .touch_idx(touch_i), .ages(ages_flat)
    );

    always_comb begin
        logic               donor_f;
        logic [IDX_W-1:0]   donor_i;
        logic [IDX_W-1:0]   vict;
        logic [TOT_W-1:0]   room;
        logic [DEPTH_W-1:0] dnew;

        s_d     = s_q;
        kind    = MISS_IDLE;
        touch_v = 1'b0;
        touch_i = '0;
        donor_f = 1'b0;
        donor_i = '0;
        vict    = free_i;
        room    = '0;
        dnew    = '0;

        // one prefetch request per cycle, lowest entry first
        s_d.pf_v = pend_f;
        s_d.pf_line = s_q.tab[pend_i].nreq;
        if (pend_f) s_d.tab[pend_i].nreq = s_q.tab[pend_i].nreq + 1'b1;

        // in-order line return
        if (fill_valid) begin
            for (int i = 0; i < NUM_STREAMS; i++) begin
                if (s_q.tab[i].valid && s_q.tab[i].ret == fill_line && s_q.tab[i].ret != s_q.tab[i].nreq)
                    s_d.tab[i].ret = s_q.tab[i].ret + 1'b1;
            end
        end

        // donor: least recently hit other stream with depth above 1
        for (int i = 0; i < NUM_STREAMS; i++) begin
            if (s_q.tab[i].valid && IDX_W'(i) != hit_i && s_q.tab[i].depth > DEPTH_W'(1) &&
                (!donor_f || age[i] > age[donor_i])) begin
                donor_f = 1'b1;
                donor_i = IDX_W'(i);
            end
        end

        if (miss_valid) begin
            if (hit_f) begin
                kind    = (mline >= s_q.tab[hit_i].ret) ? MISS_FLIGHT : MISS_READY;
                touch_v = 1'b1;
                touch_i = hit_i;
                s_d.tab[hit_i].head = mline + 1'b1;
                if (kind == MISS_FLIGHT && s_q.tab[hit_i].depth < DEPTH_W'(MAX_DEPTH)) begin
                    if (tot < TOT_W'(CAPACITY)) begin
                        s_d.tab[hit_i].depth = s_q.tab[hit_i].depth + 1'b1;
                    end else if (donor_f) begin
                        s_d.tab[hit_i].depth   = s_q.tab[hit_i].depth + 1'b1;
                        s_d.tab[donor_i].depth = s_q.tab[donor_i].depth - 1'b1;
                    end
                end
            end else begin
                kind = MISS_NEW;
                if (!free_f) begin
                    for (int i = 0; i < NUM_STREAMS; i++)
                        if (age[i] == IDX_W'(NUM_STREAMS - 1)) vict = IDX_W'(i);
                end
                room = TOT_W'(CAPACITY) - (tot - (s_q.tab[vict].valid ? TOT_W'(s_q.tab[vict].depth) : '0));
                dnew = (room < TOT_W'(init_c)) ? DEPTH_W'(room) : init_c;
                touch_v = 1'b1;
                touch_i = vict;
                s_d.tab[vict].valid = 1'b1;
                s_d.tab[vict].head  = mline + 1'b1;
                s_d.tab[vict].nreq  = mline + 1'b1;
                s_d.tab[vict].ret   = mline + 1'b1;
                s_d.tab[vict].depth = dnew;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pf_valid = s_q.pf_v;
    assign pf_line  = s_q.pf_line;
    assign st_total = tot;
    always_comb begin
        for (int i = 0; i < NUM_STREAMS; i++) begin
            st_valid[i] = s_q.tab[i].valid;
            st_depth[i*DEPTH_W +: DEPTH_W] = s_q.tab[i].depth;
        end
    end

    assert_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_total <= TOT_W'(CAPACITY));

    assert_quiet_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |=> st_valid == $past(st_valid));

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!pf_valid && st_valid == '0));

    generate
        for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_chk
            assert_depth_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
                st_valid[g] |-> st_depth[g*DEPTH_W +: DEPTH_W] <= DEPTH_W'(MAX_DEPTH));
        end
    endgenerate
endmodule

// File: tb/stream_prefetch_engine_test.sv
module stream_prefetch_engine_test;
    localparam int NS = 4, MD = 4, CAP = 8, AW = 32;
    localparam int DW = 3, LW = 25, TW = 4;

    logic clk = 0, rst_n = 0;
    logic [DW-1:0] cfg_init_depth = 3'd2;
    logic miss_valid = 0, fill_valid = 0;
    logic [AW-1:0] miss_addr = '0;
    logic [LW-1:0] fill_line = '0;
    logic pf_valid;
    logic [LW-1:0] pf_line;
    logic [NS-1:0] st_valid;
    logic [NS*DW-1:0] st_depth;
    logic [TW-1:0] st_total;

    int checks = 0, fails = 0, ngot = 0, cyc = 0;
    logic [LW-1:0] got [64];
    bit done = 0;

    always #4 clk = ~clk;

    stream_prefetch_engine #(.NUM_STREAMS(NS), .MAX_DEPTH(MD), .CAPACITY(CAP), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_init_depth(cfg_init_depth), .miss_valid(miss_valid),
        .miss_addr(miss_addr), .fill_valid(fill_valid), .fill_line(fill_line), .pf_valid(pf_valid),
        .pf_line(pf_line), .st_valid(st_valid), .st_depth(st_depth), .st_total(st_total)
    );

    always @(negedge clk) begin
        cyc++;
        if (pf_valid && ngot < 64) begin got[ngot] = pf_line; ngot++; end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk); rst_n = 0; idle(2); rst_n = 1; idle(1); ngot = 0;
    endtask

    task automatic miss(input int line);
        @(negedge clk); miss_valid = 1; miss_addr = AW'(line) << 7;
        @(negedge clk); miss_valid = 0;
    endtask

    task automatic fill(input int line);
        @(negedge clk); fill_valid = 1; fill_line = LW'(line);
        @(negedge clk); fill_valid = 0;
    endtask

    function automatic int dep(input int i);
        return int'(st_depth[i*DW +: DW]);
    endfunction

    task automatic expect_reqs(input string tag, input int n, input int base);
        idle(10);
        check(ngot == n, {tag, " request count"}, ngot, n);
        for (int k = 0; k < n && k < ngot; k++)
            check(got[k] == LW'(base + k), {tag, " request line"}, int'(got[k]), base + k);
        ngot = 0;
    endtask

    task automatic t_reset_r1;
        do_reset();
        check(st_valid == '0, "R1 valid", int'(st_valid), 0);
        check(st_total == '0, "R1 total", int'(st_total), 0);
        check(pf_valid == 1'b0, "R1 pf_valid", int'(pf_valid), 0);
    endtask

    task automatic t_ignore_r8;
        do_reset();
        @(negedge clk); miss_valid = 0; miss_addr = 32'h700 << 7; idle(6);
        check(st_valid == '0, "R8 no stream", int'(st_valid), 0);
        check(ngot == 0, "R8 no request", ngot, 0);
    endtask

    task automatic t_single_stream;
        do_reset();
        miss('h100);
        expect_reqs("R2 alloc", 2, 'h101);
        check(dep(0) == 2, "R2 depth", dep(0), 2);
        miss('h101);                       // in flight, budget free
        expect_reqs("R6 grow", 2, 'h103);
        check(dep(0) == 3, "R6 depth", dep(0), 3);
        for (int l = 'h101; l <= 'h104; l++) fill(l);
        miss('h103);                       // already returned
        expect_reqs("R5 advance", 2, 'h105);
        check(dep(0) == 3, "R7 depth kept", dep(0), 3);
        miss('h105);
        expect_reqs("R6 grow to max", 3, 'h107);
        miss('h106);
        expect_reqs("R5 topup", 1, 'h10A);
        check(dep(0) == MD, "R3 ceiling", dep(0), MD);
    endtask

    task automatic t_sharing;
        do_reset();
        miss('h100); miss('h200); miss('h300); miss('h400);
        idle(12); ngot = 0;
        check(st_total == CAP, "R4 budget full", int'(st_total), CAP);
        miss('h401);                       // steal from entry 0
        expect_reqs("R6 steal", 2, 'h403);
        check(dep(3) == 3, "R6 taker", dep(3), 3);
        check(dep(0) == 1, "R6 donor LRU", dep(0), 1);
        miss('h301);                       // entry 0 at 1, so entry 1 gives
        expect_reqs("R9 donor order", 2, 'h303);
        check(dep(1) == 1, "R9 donor skip", dep(1), 1);
        check(dep(0) == 1, "R6 min kept", dep(0), 1);
        check(st_total == CAP, "R4 total", int'(st_total), CAP);
        miss('h500);                       // table full, replaces entry 0
        expect_reqs("R2 replace", 1, 'h501);
        check(dep(0) == 1, "R2 leftover budget", dep(0), 1);
        check(st_total == CAP, "R4 after replace", int'(st_total), CAP);
    endtask

    task automatic t_clamp;
        do_reset();
        cfg_init_depth = 3'd7;
        miss('h800);
        expect_reqs("R2 clamp", MD, 'h801);
        check(dep(0) == MD, "R3 clamp depth", dep(0), MD);
        cfg_init_depth = 3'd2;
    endtask

    initial begin
        t_reset_r1();
        t_ignore_r8();
        t_single_stream();
        t_sharing();
        t_clamp();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule